// File: doc/BRIEF.md
# Double-Ended Hardware Ring Queue

This block is one queue held entirely in hardware. Several requesters share it through a request port. Each request names one of four operations: append at the tail, remove from the head, insert at the head, or remove from the tail. A fixed-priority arbiter serialises the requesters, so every change to the store and to the indexes happens in a single ordered place. Each granted request returns a response one cycle later. The response gives an error bit and, for removals, the data word and the side word.

A configuration write sets three things: the ring length in slots, an element-size code and an operating mode. Illegal combinations are refused. A refused write raises a sticky error flag and leaves the queue disabled. The mode decides two things: which head and tail operations are allowed, and whether each entry takes one slot or two. In the two-slot modes the extra slot holds a credentials or length word. In the queue-manager mode the block also keeps a running count of entries and a running sum of the length fields they carry. A separate clear pulse empties the queue and keeps the configuration.

Top module: `dq_ring_mgr`

## Requirements
- R1: A configuration write is accepted only when all of these hold: mode below 4, size code below 7, ring length from 1 to DEPTH, and an even length in modes 2 and 3. After an accepted write, `ring_en`=1, `cfg_err`=0, `size_o` equals the length and the queue is empty. After a refused write, `cfg_err`=1 and `ring_en`=0.
- R2: Mode 3 (queue manager) is accepted only with size code 1 (8 bytes). Any other code in mode 3 is refused as in R1.
- R3: In modes 2 and 3 each entry uses two slots, so `occ_o` moves by 2 per operation. In modes 0 and 1 it moves by 1. `free_o` always equals `size_o - occ_o`.
- R4: In mode 0, head insert (op 2) and tail removal (op 3) get an error response and change nothing.
- R5: Op 0 appends at the tail and op 1 removes from the head. Op 2 inserts ahead of the head and op 3 removes the most recent tail entry. A removal returns the entry's data on `rsp_data`. It returns the side word on `rsp_side` in modes 2 and 3, and 0 in modes 0 and 1.
- R6: Both of these get an error response and leave the state unchanged: a push that would take `occ_o` above the length, and a pop on an empty queue. `full_o` is 1 exactly when one more entry would not fit.
- R7: A `ring_clr` pulse empties the queue (occupancy, head and tail) and keeps the mode, the length and `ring_en`.
- R8: Among the valid requesters, the lowest index is granted in that same cycle. Only one grant is given per cycle. The response, tagged with `rsp_id`, appears on the next cycle. No request is granted in a cycle that has `cfg_wr` or `ring_clr`.
- R9: In mode 3, `qm_count` equals the number of entries. `qm_bytes` equals the sum of bits [LEN_W-1:0] of the side words of the queued entries. Outside mode 3 both read 0.
- R10: While `ring_en`=0, every request gets an error response.
- R11: The head and tail indexes wrap modulo the configured length. FIFO and LIFO order hold across the wrap point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_size | input | SZ_W | Ring length in slots |
| cfg_elsz | input | 3 | Element size code (4 << code bytes, 7 illegal) |
| cfg_mode | input | 3 | 0 plain, 1 message, 2 credentials, 3 queue manager |
| ring_clr | input | 1 | Empty the queue, keep configuration |
| req_valid | input | NREQ | Request valid per requester |
| req_op | input | 2*NREQ | Operation per requester: 0 push tail, 1 pop head, 2 push head, 3 pop tail |
| req_data | input | NREQ*DATA_W | Data word per requester |
| req_side | input | NREQ*DATA_W | Side (credentials/length) word per requester |
| grant | output | NREQ | One-hot grant, same cycle |
| rsp_valid | output | 1 | Response strobe |
| rsp_id | output | IDW | Index of the requester answered |
| rsp_err | output | 1 | Request refused |
| rsp_data | output | DATA_W | Removed data word |
| rsp_side | output | DATA_W | Removed side word |
| ring_en | output | 1 | Queue configured and usable |
| cfg_err | output | 1 | Last configuration write refused |
| size_o | output | SZ_W | Ring length in slots |
| free_o | output | SZ_W | Free slots |
| occ_o | output | SZ_W | Occupied slots |
| full_o | output | 1 | No room for one more entry |
| qm_count | output | SZ_W | Entry count in queue-manager mode |
| qm_bytes | output | QB_W | Sum of queued length fields in queue-manager mode |

## Verification
The hardest case to reach from the ports is an index wrap in the middle of mixed head and tail traffic in a two-slot mode. There the decremented head must land on the last even slot and the paired side slot must follow it. The bench sweeps every mode over several ring lengths, including odd lengths for the one-slot modes and the full store depth. It drives a long pseudo-random mix of the four operations, weighted toward pushes, so the queue fills, drains and crosses index zero in both directions many times. A bench-side double-ended queue predicts every response, occupancy and length sum.

// File: rtl/dq_ring_pkg.sv
package dq_ring_pkg;

   typedef enum logic [2:0] {
      RM_PLAIN = 3'd0,
      RM_MSG   = 3'd1,
      RM_CRED  = 3'd2,
      RM_QMGR  = 3'd3
   } ring_mode_e;

   typedef enum logic [1:0] {
      OP_PUSH_TAIL = 2'd0,
      OP_POP_HEAD  = 2'd1,
      OP_PUSH_HEAD = 2'd2,
      OP_POP_TAIL  = 2'd3
   } ring_op_e;

   localparam logic [2:0] ELSZ_ILLEGAL = 3'd7;
   localparam logic [2:0] ELSZ_QMGR    = 3'd1;

endpackage

// File: rtl/dq_ring_arb.sv
module dq_ring_arb #(
   parameter int NREQ = 2,
   parameter int IDW  = 1
) (
   input  logic [NREQ-1:0] req,
   input  logic            block,
   output logic [NREQ-1:0] grant,
   output logic [IDW-1:0]  gid,
   output logic            fire
);
   logic [NREQ:0] taken;
   assign taken[0] = 1'b0;

   for (genvar i = 0; i < NREQ; i++) begin : g_chain
      assign grant[i]   = req[i] & ~taken[i] & ~block;
      assign taken[i+1] = taken[i] | req[i];
   end

   assign fire = |grant;

   always_comb begin
      gid = '0;
      for (int i = 0; i < NREQ; i++)
         if (grant[i]) gid = IDW'(i);
   end
endmodule

// File: rtl/dq_ring_cfg.sv
module dq_ring_cfg
   import dq_ring_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int SZ_W  = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_wr,
   input  logic [SZ_W-1:0] cfg_size,
   input  logic [2:0]      cfg_elsz,
   input  logic [2:0]      cfg_mode,
   output logic            ring_en,
   output logic            cfg_err,
   output logic [SZ_W-1:0] size_q,
   output ring_mode_e      mode_q,
   output logic [SZ_W-1:0] step
);
   logic legal, two_slot_req;

   always_comb begin
      two_slot_req = (cfg_mode == 3'd2) || (cfg_mode == 3'd3);
      legal = (cfg_mode < 3'd4)
            && (cfg_elsz != ELSZ_ILLEGAL)
            && !((cfg_mode == 3'd3) && (cfg_elsz != ELSZ_QMGR))
            && (cfg_size != '0)
            && (cfg_size <= SZ_W'(DEPTH))
            && !(two_slot_req && cfg_size[0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ring_en <= 1'b0;
         cfg_err <= 1'b0;
         size_q  <= '0;
         mode_q  <= RM_PLAIN;
      end else if (cfg_wr) begin
         ring_en <= legal;
         cfg_err <= !legal;
         if (legal) begin
            size_q <= cfg_size;
            mode_q <= ring_mode_e'(cfg_mode);
         end
      end
   end

   assign step = ((mode_q == RM_CRED) || (mode_q == RM_QMGR)) ? SZ_W'(2) : SZ_W'(1);
endmodule

// File: rtl/dq_ring_core.sv
module dq_ring_core
   import dq_ring_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 32,
   parameter int LEN_W  = 16,
   parameter int SZ_W   = 5,
   parameter int QB_W   = 21,
   parameter int IDW    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              en,
   input  ring_mode_e        mode,
   input  logic [SZ_W-1:0]   size,
   input  logic [SZ_W-1:0]   step,
   input  logic              fire,
   input  ring_op_e          op,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] wside,
   input  logic [IDW-1:0]    wid,
   output logic              rsp_valid,
   output logic [IDW-1:0]    rsp_id,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_data,
   output logic [DATA_W-1:0] rsp_side,
   output logic [SZ_W-1:0]   occ,
   output logic [QB_W-1:0]   qm_bytes
);
   localparam int IW = $clog2(DEPTH);

   logic [DATA_W-1:0] store [DEPTH];
   logic [SZ_W-1:0]   head_q, tail_q, occ_q;
   logic [SZ_W-1:0]   head_up, head_dn, tail_up, tail_dn, slot_a, slot_b;
   logic [IW-1:0]     ia, ib;
   logic              two_slot, is_push, refuse, ok;
   logic [QB_W-1:0]   len_in, len_out;

   always_comb begin
      two_slot = (mode == RM_CRED) || (mode == RM_QMGR);
      is_push  = (op == OP_PUSH_TAIL) || (op == OP_PUSH_HEAD);
      refuse   = !en
               || ((mode == RM_PLAIN) && ((op == OP_PUSH_HEAD) || (op == OP_POP_TAIL)))
               || (is_push && ((occ_q + step) > size))
               || (!is_push && (occ_q == '0));
      ok       = fire && !refuse;
      head_up  = ((head_q + step) >= size) ? (head_q + step - size) : (head_q + step);
      head_dn  = (head_q < step) ? (head_q + size - step) : (head_q - step);
      tail_up  = ((tail_q + step) >= size) ? (tail_q + step - size) : (tail_q + step);
      tail_dn  = (tail_q < step) ? (tail_q + size - step) : (tail_q - step);
      unique case (op)
         OP_PUSH_TAIL: slot_a = tail_q;
         OP_POP_HEAD:  slot_a = head_q;
         OP_PUSH_HEAD: slot_a = head_dn;
         default:      slot_a = tail_dn;
      endcase
      slot_b  = slot_a + SZ_W'(1);
      ia      = slot_a[IW-1:0];
      ib      = slot_b[IW-1:0];
      len_in  = QB_W'(wside[LEN_W-1:0]);
      len_out = QB_W'(store[ib][LEN_W-1:0]);
   end

   always_ff @(posedge clk) begin
      if (ok && is_push) begin
         store[ia] <= wdata;
         if (two_slot) store[ib] <= wside;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q    <= '0;
         tail_q    <= '0;
         occ_q     <= '0;
         qm_bytes  <= '0;
         rsp_valid <= 1'b0;
         rsp_id    <= '0;
         rsp_err   <= 1'b0;
         rsp_data  <= '0;
         rsp_side  <= '0;
      end else begin
         rsp_valid <= fire;
         if (fire) begin
            rsp_id   <= wid;
            rsp_err  <= refuse;
            rsp_data <= (ok && !is_push) ? store[ia] : '0;
            rsp_side <= (ok && !is_push && two_slot) ? store[ib] : '0;
         end
         if (clear) begin
            head_q   <= '0;
            tail_q   <= '0;
            occ_q    <= '0;
            qm_bytes <= '0;
         end else if (ok) begin
            occ_q <= is_push ? (occ_q + step) : (occ_q - step);
            unique case (op)
               OP_PUSH_TAIL: tail_q <= tail_up;
               OP_POP_HEAD:  head_q <= head_up;
               OP_PUSH_HEAD: head_q <= head_dn;
               default:      tail_q <= tail_dn;
            endcase
            if (mode == RM_QMGR)
               qm_bytes <= is_push ? (qm_bytes + len_in) : (qm_bytes - len_out);
         end
      end
   end

   assign occ = occ_q;
endmodule

// File: rtl/dq_ring_mgr.sv
module dq_ring_mgr
   import dq_ring_pkg::*;
#(
   parameter int NREQ   = 2,
   parameter int DEPTH  = 16,
   parameter int DATA_W = 32,
   parameter int LEN_W  = 16,
   localparam int SZ_W  = $clog2(DEPTH + 3),
   localparam int IDW   = (NREQ > 1) ? $clog2(NREQ) : 1,
   localparam int QB_W  = LEN_W + SZ_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_wr,
   input  logic [SZ_W-1:0]        cfg_size,
   input  logic [2:0]             cfg_elsz,
   input  logic [2:0]             cfg_mode,
   input  logic                   ring_clr,
   input  logic [NREQ-1:0]        req_valid,
   input  logic [2*NREQ-1:0]      req_op,
   input  logic [NREQ*DATA_W-1:0] req_data,
   input  logic [NREQ*DATA_W-1:0] req_side,
   output logic [NREQ-1:0]        grant,
   output logic                   rsp_valid,
   output logic [IDW-1:0]         rsp_id,
   output logic                   rsp_err,
   output logic [DATA_W-1:0]      rsp_data,
   output logic [DATA_W-1:0]      rsp_side,
   output logic                   ring_en,
   output logic                   cfg_err,
   output logic [SZ_W-1:0]        size_o,
   output logic [SZ_W-1:0]        free_o,
   output logic [SZ_W-1:0]        occ_o,
   output logic                   full_o,
   output logic [SZ_W-1:0]        qm_count,
   output logic [QB_W-1:0]        qm_bytes
);
   if (DEPTH < 2 || (DEPTH % 2) != 0) begin : g_bad_depth
      $error("DEPTH must be even and at least 2");
   end
   if (NREQ < 1) begin : g_bad_nreq
      $error("NREQ must be at least 1");
   end
   if (LEN_W < 1 || LEN_W > DATA_W) begin : g_bad_len
      $error("LEN_W must lie in 1..DATA_W");
   end

   logic              fire;
   logic [IDW-1:0]    gid;
   ring_mode_e        mode_q;
   logic [SZ_W-1:0]   step;
   ring_op_e          sel_op;
   logic [DATA_W-1:0] sel_data, sel_side;

   dq_ring_arb #(.NREQ(NREQ), .IDW(IDW)) u_arb (
      .req   (req_valid),
      .block (cfg_wr | ring_clr),
      .grant (grant),
      .gid   (gid),
      .fire  (fire)
   );

   dq_ring_cfg #(.DEPTH(DEPTH), .SZ_W(SZ_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (cfg_wr),
      .cfg_size (cfg_size),
      .cfg_elsz (cfg_elsz),
      .cfg_mode (cfg_mode),
      .ring_en  (ring_en),
      .cfg_err  (cfg_err),
      .size_q   (size_o),
      .mode_q   (mode_q),
      .step     (step)
   );

   always_comb begin
      sel_op   = ring_op_e'(req_op[2*gid +: 2]);
      sel_data = req_data[DATA_W*gid +: DATA_W];
      sel_side = req_side[DATA_W*gid +: DATA_W];
   end

   dq_ring_core #(
      .DEPTH(DEPTH), .DATA_W(DATA_W), .LEN_W(LEN_W),
      .SZ_W(SZ_W), .QB_W(QB_W), .IDW(IDW)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (cfg_wr | ring_clr),
      .en        (ring_en),
      .mode      (mode_q),
      .size      (size_o),
      .step      (step),
      .fire      (fire),
      .op        (sel_op),
      .wdata     (sel_data),
      .wside     (sel_side),
      .wid       (gid),
      .rsp_valid (rsp_valid),
      .rsp_id    (rsp_id),
      .rsp_err   (rsp_err),
      .rsp_data  (rsp_data),
      .rsp_side  (rsp_side),
      .occ       (occ_o),
      .qm_bytes  (qm_bytes)
   );

   assign free_o   = size_o - occ_o;
   assign full_o   = ring_en && ((occ_o + step) > size_o);
   assign qm_count = (mode_q == RM_QMGR) ? (occ_o >> 1) : '0;
endmodule

// File: rtl/dq_ring_mgr_chk.sv
module dq_ring_mgr_chk #(
   parameter int NREQ = 2,
   parameter int SZ_W = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NREQ-1:0] grant,
   input logic            rsp_valid,
   input logic            rsp_err,
   input logic            ring_en,
   input logic            cfg_err,
   input logic            cfg_wr,
   input logic            ring_clr,
   input logic [SZ_W-1:0] occ_o,
   input logic [SZ_W-1:0] free_o,
   input logic [SZ_W-1:0] size_o,
   input logic [2:0]      mode_q
);
   p_refused_cfg_disables_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !ring_en);

   p_two_slot_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q >= 3'd2) |-> (occ_o[0] == 1'b0));

   p_free_plus_occ_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ring_en |-> ((free_o + occ_o) == size_o));

   p_refusal_keeps_occ_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> $stable(occ_o));

   p_occ_within_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
      occ_o <= size_o);

   p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ring_clr || cfg_wr) |=> (occ_o == '0));

   p_single_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   p_grant_answered_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant) |=> rsp_valid);
endmodule

bind dq_ring_mgr dq_ring_mgr_chk #(.NREQ(NREQ), .SZ_W(SZ_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .grant     (grant),
   .rsp_valid (rsp_valid),
   .rsp_err   (rsp_err),
   .ring_en   (ring_en),
   .cfg_err   (cfg_err),
   .cfg_wr    (cfg_wr),
   .ring_clr  (ring_clr),
   .occ_o     (occ_o),
   .free_o    (free_o),
   .size_o    (size_o),
   .mode_q    (mode_q)
);

// File: tb/dq_ring_mgr_test.sv
`timescale 1ns/1ps
module dq_ring_mgr_test;
   localparam int NREQ = 2, DEPTH = 16, DATA_W = 32, LEN_W = 16;
   localparam int SZ_W = $clog2(DEPTH + 3);
   localparam int QB_W = LEN_W + SZ_W;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_wr = 1'b0, ring_clr = 1'b0;
   logic [SZ_W-1:0] cfg_size = '0;
   logic [2:0] cfg_elsz = '0, cfg_mode = '0;
   logic [NREQ-1:0] req_valid = '0;
   logic [2*NREQ-1:0] req_op = '0;
   logic [NREQ*DATA_W-1:0] req_data = '0, req_side = '0;
   logic [NREQ-1:0] grant;
   logic rsp_valid, rsp_err, ring_en, cfg_err, full_o;
   logic [0:0] rsp_id;
   logic [DATA_W-1:0] rsp_data, rsp_side;
   logic [SZ_W-1:0] size_o, free_o, occ_o, qm_count;
   logic [QB_W-1:0] qm_bytes;

   dq_ring_mgr #(.NREQ(NREQ), .DEPTH(DEPTH), .DATA_W(DATA_W), .LEN_W(LEN_W)) uut (.*);

   always #2 clk = ~clk;

   int total = 0, bad = 0;
   bit finished = 0;
   logic [31:0] md[$];
   logic [31:0] ms[$];
   int m_mode = 0, m_size = 0;
   bit m_en = 0;
   logic [15:0] lf = 16'hACE1;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int stp();
      return (m_mode >= 2) ? 2 : 1;
   endfunction

   task automatic check_status(input string tag);
      int sum = 0;
      int cnt = md.size();
      foreach (ms[i]) sum += int'(ms[i][15:0]);
      chk(occ_o == SZ_W'(cnt * stp()), {tag, " R3 occ"}, occ_o, cnt * stp());
      chk(free_o == SZ_W'(m_size - cnt * stp()), {tag, " R3 free"}, free_o, m_size - cnt * stp());
      chk(full_o == (m_en && ((cnt + 1) * stp() > m_size)), {tag, " R6 full"}, full_o,
          m_en && ((cnt + 1) * stp() > m_size));
      chk(qm_count == SZ_W'((m_mode == 3) ? cnt : 0), {tag, " R9 count"}, qm_count,
          (m_mode == 3) ? cnt : 0);
      chk(qm_bytes == QB_W'((m_mode == 3) ? sum : 0), {tag, " R9 bytes"}, qm_bytes,
          (m_mode == 3) ? sum : 0);
   endtask

   task automatic configure(input int mode, input int elsz, input int size, input string tag);
      bit legal;
      @(negedge clk);
      cfg_wr = 1'b1; cfg_mode = 3'(mode); cfg_elsz = 3'(elsz); cfg_size = SZ_W'(size);
      @(negedge clk);
      cfg_wr = 1'b0;
      legal = (mode < 4) && (elsz < 7) && !(mode == 3 && elsz != 1) && size >= 1
              && size <= DEPTH && !(mode >= 2 && (size % 2) == 1);
      chk(cfg_err == !legal, {tag, " R1 R2 cfg_err"}, cfg_err, !legal);
      chk(ring_en == legal, {tag, " R1 R2 ring_en"}, ring_en, legal);
      m_en = legal;
      if (legal) begin
         m_mode = mode; m_size = size;
         md.delete(); ms.delete();
         chk(size_o == SZ_W'(size), {tag, " R1 size"}, size_o, size);
         chk(occ_o == '0, {tag, " R1 empty"}, occ_o, 0);
      end
   endtask

   task automatic do_op(input int id, input int o, input logic [31:0] d, input logic [31:0] s,
                        input string tag);
      bit perr;
      logic [31:0] ed = 32'h0, es = 32'h0;
      int cnt = md.size();
      perr = !m_en || (m_mode == 0 && o >= 2) ||
             ((o == 0 || o == 2) && (cnt + 1) * stp() > m_size) ||
             ((o == 1 || o == 3) && cnt == 0);
      @(negedge clk);
      req_valid[id] = 1'b1;
      req_op[2*id +: 2] = 2'(o);
      req_data[32*id +: 32] = d;
      req_side[32*id +: 32] = s;
      #1;
      chk(grant == NREQ'(1 << id), {tag, " R8 grant"}, grant, 1 << id);
      @(negedge clk);
      req_valid = '0;
      if (!perr) begin
         case (o)
            0: begin md.push_back(d); ms.push_back(s); end
            2: begin md.push_front(d); ms.push_front(s); end
            1: begin ed = md.pop_front(); es = ms.pop_front(); end
            default: begin ed = md.pop_back(); es = ms.pop_back(); end
         endcase
         if (m_mode < 2) es = 32'h0;
      end
      chk(rsp_valid == 1'b1, {tag, " R8 rsp_valid"}, rsp_valid, 1);
      chk(rsp_id == 1'(id), {tag, " R8 rsp_id"}, rsp_id, id);
      chk(rsp_err == perr, {tag, " R4 R6 R10 rsp_err"}, rsp_err, perr);
      chk(rsp_data == ed, {tag, " R5 R11 data"}, rsp_data, ed);
      chk(rsp_side == es, {tag, " R5 side"}, rsp_side, es);
      check_status(tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ring_en == 1'b0, "reset R1 ring_en", ring_en, 0);
      chk(cfg_err == 1'b0, "reset R1 cfg_err", cfg_err, 0);
      chk(occ_o == '0, "reset R3 occ", occ_o, 0);
      chk(rsp_valid == 1'b0, "reset R8 rsp_valid", rsp_valid, 0);

      // R10: requests on an unconfigured ring are refused
      do_op(0, 0, 32'h1111, 32'h2, "disabled");

      // R1 R2: every mode and size-code pairing
      for (int m = 0; m < 8; m++)
         for (int e = 0; e < 8; e++)
            configure(m, e, 4, "cfg sweep");
      configure(2, 2, 5, "odd two-slot R1");
      configure(0, 0, 0, "zero size R1");
      configure(1, 0, DEPTH + 1, "oversize R1");
      do_op(1, 1, 32'h0, 32'h0, "refused cfg R10");

      // R4 R5 R6 R11: sweep modes and lengths with a long operation mix
      for (int m = 0; m < 4; m++) begin
         for (int k = 0; k < 4; k++) begin
            int sz;
            int lens_one[4] = '{1, 3, 5, DEPTH};
            int lens_two[4] = '{2, 4, 6, DEPTH};
            sz = (m >= 2) ? lens_two[k] : lens_one[k];
            configure(m, (m == 3) ? 1 : k, sz, "mode sweep");
            for (int n = 0; n < 70; n++) begin
               int o;
               lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
               case (lf[2:0])
                  3'd0, 3'd1, 3'd2, 3'd7: o = 0;
                  3'd3: o = 2;
                  3'd4, 3'd5: o = 1;
                  default: o = 3;
               endcase
               do_op(n % 2, o, {lf, ~lf}, {~lf, 8'h0, lf[7:0]}, "sweep R11");
            end
         end
      end

      // R8: simultaneous requesters, lowest index wins
      configure(1, 0, 8, "arb");
      @(negedge clk);
      req_valid = 2'b11;
      req_op = 4'b0000;
      req_data = {32'hBBBB, 32'hAAAA};
      #1;
      chk(grant == 2'b01, "R8 priority grant", grant, 1);
      @(negedge clk);
      req_valid = '0;
      chk(rsp_id == 1'b0, "R8 priority rsp_id", rsp_id, 0);
      md.push_back(32'hAAAA); ms.push_back(32'h0);
      do_op(0, 1, 32'h0, 32'h0, "R8 winner stored");

      // R7: clear keeps configuration
      configure(2, 3, 8, "clear");
      do_op(0, 0, 32'h10, 32'h20, "pre clear R7");
      do_op(1, 2, 32'h11, 32'h21, "pre clear R7");
      @(negedge clk);
      ring_clr = 1'b1;
      @(negedge clk);
      ring_clr = 1'b0;
      md.delete(); ms.delete();
      chk(occ_o == '0, "R7 occ after clear", occ_o, 0);
      chk(ring_en == 1'b1, "R7 ring_en kept", ring_en, 1);
      chk(size_o == SZ_W'(8), "R7 size kept", size_o, 8);
      do_op(0, 0, 32'h33, 32'h44, "post clear R7");
      do_op(0, 3, 32'h0, 32'h0, "post clear R7");

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule